// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the 16-bit program counter of a small sequenced processor, together with a 16-bit link register (XY) and a 16-bit jump-target register (J) that is assembled from two bytes off the 8-bit data bus. Everything it does is driven by strobes from an external sequencer. There is one select vector for the shared 16-bit address bus and several load strobes. The block returns the address bus and a combinational branch-condition result.

The program counter advances in two phases. In the first, the PC is placed on the address bus and a dedicated 16-bit incrementer result is captured into an Inc register. In the second, Inc is placed on the bus and written back into the PC.

All control flow is built by the sequencer from one rule: whatever source is on the bus can be loaded into the PC or into XY.
- A goto places J on the bus and loads the PC.
- A call first copies the PC into XY, then loads J into the PC.
- A return places XY on the bus and loads the PC.
- A conditional branch loads J into the PC only when the selected flag test holds.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, PC, Inc, XY and J all become 0x0000.
- R2: `addr_sel` is one-hot with bit 0 = PC, bit 1 = Inc, bit 2 = XY, bit 3 = J, bit 4 = external M. The address bus shows the selected source in the same cycle. With no bit set, the bus is 0x0000.
- R3: When `inc_latch` is high at an edge, Inc captures the address bus plus one, and 0xFFFF wraps to 0x0000.
- R4: When `ld_pc` is high at an edge, PC takes the address bus value. A two-phase increment (PC selected with `inc_latch`, then Inc selected with `ld_pc`) advances the PC by one.
- R5: `ld_j_hi` writes `data_bus` into J bits 15:8 and `ld_j_lo` writes it into J bits 7:0. A goto (J selected with `ld_pc`) puts that 16-bit value into the PC.
- R6: When `ld_xy` is high at an edge, XY takes the address bus value. A call (PC selected with `ld_xy`, then J selected with `ld_pc`) leaves the return address in XY and the target in the PC.
- R7: A 16-bit move copies M, XY or J into either PC or XY. Moving XY into the PC acts as a return or an indirect jump.
- R8: `br_code` selects the flag test: 0 = sign set, 1 = carry set, 2 = zero set, 3 = zero clear. `cond_met` shows the result combinationally.
- R9: When `ld_pc_cond` is high and `cond_met` is high at an edge, PC takes the address bus value (branch taken).
- R10: When `ld_pc_cond` is high and `cond_met` is low, the PC keeps its already-incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 5 | One-hot address bus source select |
| m_addr | input | 16 | External 16-bit M register value |
| data_bus | input | 8 | Byte bus used to fill J |
| ld_j_hi | input | 1 | Load J upper byte |
| ld_j_lo | input | 1 | Load J lower byte |
| inc_latch | input | 1 | Capture incrementer output into Inc |
| ld_pc | input | 1 | Unconditional PC load from bus |
| ld_xy | input | 1 | XY load from bus |
| ld_pc_cond | input | 1 | PC load from bus if condition holds |
| br_code | input | 2 | Flag test selector |
| flag_s | input | 1 | Sign flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| addr_bus | output | 16 | 16-bit address bus |
| cond_met | output | 1 | Selected flag test result |

## Verification
The bus value and `cond_met` are combinational, so both are due in the same cycle as the select or flag change. Every register load becomes visible one clock edge after its strobe, and only when that register is then selected onto the bus. The bench drives every strobe 1 ns after a rising edge and releases it after the next edge. It reads a register by selecting it between edges and sampling 1 ns later, so each load is observed exactly one edge after it was requested.

// File: rtl/pcb_pkg.sv
// Package: shared encodings for the program counter and branch unit.
// Assumes the address bus source order below is the one the sequencer uses.
package pcb_pkg;
    localparam int ADDR_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_SRC  = 5;

    localparam int SRC_PC   = 0;
    localparam int SRC_INC  = 1;
    localparam int SRC_XY   = 2;
    localparam int SRC_J    = 3;
    localparam int SRC_M    = 4;

    typedef enum logic [1:0] {
        COND_SIGN   = 2'd0,
        COND_CARRY  = 2'd1,
        COND_ZERO   = 2'd2,
        COND_NZERO  = 2'd3
    } cond_e;
endpackage

// File: rtl/pcb_incrementer.sv
// Module: ripple half-adder chain that adds one to its input.
// Assumes wrap-around on overflow; no carry out is reported.
module pcb_incrementer #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W:0] carry;

    assign carry[0] = 1'b1;

    // one half-adder per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i]    = din[i] ^ carry[i];
        assign carry[i+1] = din[i] & carry[i];
    end
endmodule

// File: rtl/pcb_addr_mux.sv
// Module: AND-OR bus driver for N sources of W bits each.
// Assumes sel is one-hot or zero; an empty select yields zero.
module pcb_addr_mux #(
    parameter int W = 16,
    parameter int N = 5
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] srcs,
    output logic [W-1:0]   bus
);
    logic [W-1:0] gated [N];

    // mask each source with its own select bit
    for (genvar k = 0; k < N; k++) begin : g_src
        assign gated[k] = srcs[k*W +: W] & {W{sel[k]}};
    end

    // merge all masked sources onto the bus
    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) begin
            bus = bus | gated[k];
        end
    end
endmodule

// File: rtl/pcb_cond_eval.sv
// Module: picks one flag test from a 2-bit code.
// Assumes flags are stable while the code is applied.
module pcb_cond_eval
    import pcb_pkg::*;
(
    input  logic [1:0] code,
    input  logic       s_flag,
    input  logic       c_flag,
    input  logic       z_flag,
    output logic       met
);
    // decode the flag test
    always_comb begin
        unique case (cond_e'(code))
            COND_SIGN:  met = s_flag;
            COND_CARRY: met = c_flag;
            COND_ZERO:  met = z_flag;
            COND_NZERO: met = ~z_flag;
            default:    met = 1'b0;
        endcase
    end
endmodule

// File: rtl/pc_branch_unit.sv
// Module: program counter, Inc, XY link and J target registers around a
// shared 16-bit address bus. Assumes the sequencer drives one-hot selects
// and never asserts two conflicting PC loads it cares to distinguish.
module pc_branch_unit
    import pcb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] addr_sel,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic [BYTE_W-1:0]  data_bus,
    input  logic               ld_j_hi,
    input  logic               ld_j_lo,
    input  logic               inc_latch,
    input  logic               ld_pc,
    input  logic               ld_xy,
    input  logic               ld_pc_cond,
    input  logic [1:0]         br_code,
    input  logic               flag_s,
    input  logic               flag_c,
    input  logic               flag_z,
    output logic [ADDR_W-1:0]  addr_bus,
    output logic               cond_met
);
    localparam int JH_LO = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0]        pc_q;
    logic [ADDR_W-1:0]        inc_q;
    logic [ADDR_W-1:0]        xy_q;
    logic [ADDR_W-1:0]        j_q;
    logic [ADDR_W-1:0]        inc_next;
    logic [NUM_SRC*ADDR_W-1:0] src_flat;
    logic                     pc_we;

    // pack the bus sources in select-bit order
    always_comb begin
        src_flat = '0;
        src_flat[SRC_PC*ADDR_W  +: ADDR_W] = pc_q;
        src_flat[SRC_INC*ADDR_W +: ADDR_W] = inc_q;
        src_flat[SRC_XY*ADDR_W  +: ADDR_W] = xy_q;
        src_flat[SRC_J*ADDR_W   +: ADDR_W] = j_q;
        src_flat[SRC_M*ADDR_W   +: ADDR_W] = m_addr;
    end

    pcb_addr_mux #(.W(ADDR_W), .N(NUM_SRC)) u_mux (
        .sel  (addr_sel),
        .srcs (src_flat),
        .bus  (addr_bus)
    );

    pcb_incrementer #(.W(ADDR_W)) u_inc (
        .din  (addr_bus),
        .dout (inc_next)
    );

    pcb_cond_eval u_cond (
        .code   (br_code),
        .s_flag (flag_s),
        .c_flag (flag_c),
        .z_flag (flag_z),
        .met    (cond_met)
    );

    assign pc_we = ld_pc | (ld_pc_cond & cond_met);

    // program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= addr_bus;
    end

    // incrementer holding register
    always_ff @(posedge clk) begin
        if (!rst_n)         inc_q <= '0;
        else if (inc_latch) inc_q <= inc_next;
    end

    // link register
    always_ff @(posedge clk) begin
        if (!rst_n)     xy_q <= '0;
        else if (ld_xy) xy_q <= addr_bus;
    end

    // jump target register, filled one byte at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q <= '0;
        end else begin
            if (ld_j_hi) j_q[ADDR_W-1:JH_LO] <= data_bus;
            if (ld_j_lo) j_q[BYTE_W-1:0]     <= data_bus;
        end
    end
endmodule

// File: rtl/pcb_checker.sv
// Module: temporal checks on the program counter and branch unit.
// Assumes it is attached through the bind below.
module pcb_checker #(
    parameter int AW = 16,
    parameter int NS = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] addr_sel,
    input logic [AW-1:0] addr_bus,
    input logic          ld_pc,
    input logic          ld_pc_cond,
    input logic          cond_met,
    input logic          inc_latch,
    input logic          ld_xy,
    input logic [AW-1:0] pc_q,
    input logic [AW-1:0] inc_q,
    input logic [AW-1:0] xy_q
);
    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> pc_q == '0); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(addr_sel)); // R2
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) addr_sel == '0 |-> addr_bus == '0); // R2
    AST_INC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) inc_latch |=> inc_q == AW'($past(addr_bus) + 1'b1)); // R3
    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ld_pc |=> pc_q == $past(addr_bus)); // R4
    AST_XY_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ld_xy |=> xy_q == $past(addr_bus)); // R6
    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (ld_pc_cond && cond_met) |=> pc_q == $past(addr_bus)); // R9
    AST_BR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ld_pc && !(ld_pc_cond && cond_met)) |=> $stable(pc_q)); // R10
endmodule

bind pc_branch_unit pcb_checker #(.AW(16), .NS(5)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel   (addr_sel),
    .addr_bus   (addr_bus),
    .ld_pc      (ld_pc),
    .ld_pc_cond (ld_pc_cond),
    .cond_met   (cond_met),
    .inc_latch  (inc_latch),
    .ld_xy      (ld_xy),
    .pc_q       (pc_q),
    .inc_q      (inc_q),
    .xy_q       (xy_q)
);

// File: tb/pc_branch_unit_tb.sv
// Directed bench for pc_branch_unit: one task per scenario.
module pc_branch_unit_tb;
    localparam int S_PC = 0, S_INC = 1, S_XY = 2, S_J = 3, S_M = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_sel = '0;
    logic [15:0] m_addr = '0;
    logic [7:0]  data_bus = '0;
    logic        ld_j_hi = 0, ld_j_lo = 0, inc_latch = 0, ld_pc = 0, ld_xy = 0, ld_pc_cond = 0;
    logic [1:0]  br_code = '0;
    logic        flag_s = 0, flag_c = 0, flag_z = 0;
    logic [15:0] addr_bus;
    logic        cond_met;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    pc_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .m_addr(m_addr),
        .data_bus(data_bus), .ld_j_hi(ld_j_hi), .ld_j_lo(ld_j_lo),
        .inc_latch(inc_latch), .ld_pc(ld_pc), .ld_xy(ld_xy),
        .ld_pc_cond(ld_pc_cond), .br_code(br_code), .flag_s(flag_s),
        .flag_c(flag_c), .flag_z(flag_z), .addr_bus(addr_bus), .cond_met(cond_met)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with the given strobes, released afterwards
    task automatic tick(input int src, input bit lp, input bit lx, input bit il, input bit lc);
        addr_sel   = (src < 0) ? 5'd0 : 5'(1 << src);
        ld_pc      = lp;
        ld_xy      = lx;
        inc_latch  = il;
        ld_pc_cond = lc;
        @(posedge clk); #1;
        addr_sel = '0; ld_pc = 0; ld_xy = 0; inc_latch = 0; ld_pc_cond = 0;
    endtask

    // show a source on the bus between edges
    task automatic peek(input int src, output logic [15:0] v);
        addr_sel = 5'(1 << src);
        #1 v = addr_bus;
        addr_sel = '0;
        #0;
    endtask

    task automatic load_j(input logic [15:0] v);
        ld_j_hi = 1; data_bus = v[15:8];
        @(posedge clk); #1;
        ld_j_hi = 0; ld_j_lo = 1; data_bus = v[7:0];
        @(posedge clk); #1;
        ld_j_lo = 0;
    endtask

    task automatic goto_addr(input logic [15:0] v);
        load_j(v);
        tick(S_J, 1, 0, 0, 0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(S_PC, v);  check("R1 pc", v, 16'h0000);
        peek(S_INC, v); check("R1 inc", v, 16'h0000);
        peek(S_XY, v);  check("R1 xy", v, 16'h0000);
        peek(S_J, v);   check("R1 j", v, 16'h0000);
    endtask

    task automatic t_bus();
        logic [15:0] v;
        m_addr = 16'hBEEF;
        #1 check("R2 idle bus", addr_bus, 16'h0000);
        peek(S_M, v); check("R2 m on bus", v, 16'hBEEF);
    endtask

    task automatic t_increment();
        logic [15:0] v;
        goto_addr(16'h1234);
        peek(S_J, v);  check("R5 j bytes", v, 16'h1234);
        peek(S_PC, v); check("R5 goto", v, 16'h1234);
        tick(S_PC, 0, 0, 1, 0);
        peek(S_INC, v); check("R3 inc", v, 16'h1235);
        peek(S_PC, v);  check("R4 pc before write-back", v, 16'h1234);
        tick(S_INC, 1, 0, 0, 0);
        peek(S_PC, v);  check("R4 pc advanced", v, 16'h1235);
        goto_addr(16'hFFFF);
        tick(S_PC, 0, 0, 1, 0);
        tick(S_INC, 1, 0, 0, 0);
        peek(S_PC, v);  check("R3 wrap", v, 16'h0000);
    endtask

    task automatic t_call_move();
        logic [15:0] v;
        goto_addr(16'h0100);
        load_j(16'h2A80);
        tick(S_PC, 0, 1, 0, 0);
        tick(S_J, 1, 0, 0, 0);
        peek(S_XY, v); check("R6 return saved", v, 16'h0100);
        peek(S_PC, v); check("R6 call target", v, 16'h2A80);
        tick(S_XY, 1, 0, 0, 0);
        peek(S_PC, v); check("R7 return xy->pc", v, 16'h0100);
        m_addr = 16'h7007;
        tick(S_M, 0, 1, 0, 0);
        peek(S_XY, v); check("R7 m->xy", v, 16'h7007);
        tick(S_M, 1, 0, 0, 0);
        peek(S_PC, v); check("R7 m->pc", v, 16'h7007);
        tick(S_J, 0, 1, 0, 0);
        peek(S_XY, v); check("R7 j->xy", v, 16'h2A80);
    endtask

    // one conditional branch case: base PC 0x0010, target 0x4000
    task automatic t_branch(input logic [1:0] code, input bit s, input bit c, input bit z, input bit exp_met);
        logic [15:0] v;
        goto_addr(16'h0010);
        load_j(16'h4000);
        br_code = code; flag_s = s; flag_c = c; flag_z = z;
        #1 check($sformatf("R8 cond code %0d", code), {15'd0, cond_met}, {15'd0, exp_met});
        tick(S_J, 0, 0, 0, 1);
        peek(S_PC, v);
        if (exp_met) check($sformatf("R9 taken code %0d", code), v, 16'h4000);
        else         check($sformatf("R10 not taken code %0d", code), v, 16'h0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_bus();
        t_increment();
        t_call_move();
        t_branch(2'd0, 1, 0, 0, 1);
        t_branch(2'd0, 0, 1, 1, 0);
        t_branch(2'd1, 0, 1, 0, 1);
        t_branch(2'd1, 1, 0, 1, 0);
        t_branch(2'd2, 0, 0, 1, 1);
        t_branch(2'd2, 1, 1, 0, 0);
        t_branch(2'd3, 0, 0, 0, 1);
        t_branch(2'd3, 1, 1, 1, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule